// File: doc/BRIEF.md
# Paged program counter unit

This block holds the 13-bit instruction address of a small microcontroller core whose data path is only eight bits wide. The low byte of the address can be read by the core and overwritten with any data byte. The upper five bits cannot be reached directly. They are staged in a separate 5-bit page latch, which the core writes ahead of time.

The staged page reaches the address in two ways. A low-byte write copies all five latch bits into the top of the address. A literal jump or call takes only the top two latch bits and fills the remaining eleven bits from the instruction literal. Sequential fetch increments the full 13-bit address. A return loads a complete address popped from an external stack. A call presents the return address to that stack in the same cycle as the jump.

Top module: `pc_unit`

## Requirements
- R1: The asynchronous active-low reset clears the program address to 0x0000 and the page latch to 0. After release, a low-byte write of 0xAA yields address 0x00AA.
- R2: A lone increment request advances all 13 address bits by one, wrapping from 0x1FFF to 0x0000.
- R3: A low-byte write loads the address with {latch[4:0], data[7:0]} at the next clock edge. Bits 12:8 come only from the latch, with no carry from the low byte. lo_o always equals address bits 7:0.
- R4: When a low-byte write and an increment request occur in the same cycle, the low-byte write decides the new address.
- R5: A jump loads the address with {latch[4:3], lit[10:0]}. Latch bits 2:0 have no effect.
- R6: While jump and call are both high, push_o is high and push_addr_o equals the current address plus one (mod 2^13) in that same cycle. With call low, push_o stays low.
- R7: A return loads the full 13-bit popped address, and the latch has no effect on it.
- R8: The latch changes only on its own write or on reset, and it keeps its value across jumps, calls and returns. A latch write takes effect for address loads from the following cycle. A low-byte write in the same cycle still uses the previous latch value.
- R9: Priority among the address sources is return, then jump, then low-byte write, then increment. With none of them active, the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inc_i | input | 1 | Sequential increment request |
| lo_wr_i | input | 1 | Write to the low address byte |
| lo_data_i | input | 8 | Byte written to the low address byte |
| page_wr_i | input | 1 | Write to the page latch |
| page_data_i | input | 5 | Value written to the page latch |
| jump_i | input | 1 | Absolute jump or call |
| call_i | input | 1 | Qualifies a jump as a call |
| lit_i | input | 11 | Jump literal |
| ret_i | input | 1 | Return from the stack |
| pop_addr_i | input | 13 | Address popped from the stack |
| push_o | output | 1 | Push request to the stack |
| push_addr_o | output | 13 | Return address to push |
| pc_o | output | 13 | Current program address |
| lo_o | output | 8 | Readable low address byte |

## Verification
The hardest case to reach is a latch write and a low-byte write in the same cycle. Here the stale page must land in the address while the new page waits silently until a later jump or low-byte write reveals it. The vector table first stages one page and then writes a second page together with a low byte. It follows with a jump, a call and a 0x1FFF wrap, and then a bare low-byte write that exposes the retained second page. A mid-run reset followed by a low-byte write shows that the latch was cleared as well as the address.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int unsigned PC_W   = 13;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PAGE_W = PC_W - BYTE_W;
  localparam int unsigned LIT_W  = 11;

  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_INC,
    SRC_LOW,
    SRC_JUMP,
    SRC_RET
  } pc_src_e;
endpackage

// File: rtl/pc_page_latch.sv
module pc_page_latch #(
  parameter int unsigned PAGE_W = pc_pkg::PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] data_i,
  output logic [PAGE_W-1:0] page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_o <= '0;
    else if (wr_i) page_o <= data_i;
  end

  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> page_o == $past(page_o)); // R8
  AST_PAGE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> page_o == $past(data_i)); // R8
endmodule

// File: rtl/pc_src_sel.sv
module pc_src_sel (
  input  logic            inc_i,
  input  logic            lo_wr_i,
  input  logic            jump_i,
  input  logic            ret_i,
  output pc_pkg::pc_src_e src_o
);
  import pc_pkg::*;
  always_comb begin
    if (ret_i)        src_o = SRC_RET;
    else if (jump_i)  src_o = SRC_JUMP;
    else if (lo_wr_i) src_o = SRC_LOW;
    else if (inc_i)   src_o = SRC_INC;
    else              src_o = SRC_HOLD;
  end
endmodule

// File: rtl/pc_next_addr.sv
module pc_next_addr #(
  parameter int unsigned PC_W   = pc_pkg::PC_W,
  parameter int unsigned BYTE_W = pc_pkg::BYTE_W,
  parameter int unsigned LIT_W  = pc_pkg::LIT_W,
  localparam int unsigned PAGE_W = PC_W - BYTE_W
) (
  input  pc_pkg::pc_src_e   src_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [BYTE_W-1:0] lo_data_i,
  input  logic [LIT_W-1:0]  lit_i,
  input  logic [PC_W-1:0]   pop_addr_i,
  output logic [PC_W-1:0]   seq_o,
  output logic [PC_W-1:0]   next_o
);
  import pc_pkg::*;
  localparam int unsigned JHI_W = PC_W - LIT_W;

  assign seq_o = pc_i + PC_W'(1);

  always_comb begin
    unique case (src_i)
      SRC_INC:  next_o = seq_o;
      SRC_LOW:  next_o = {page_i, lo_data_i};
      // only the top page bits reach the address on a literal jump
      SRC_JUMP: next_o = {page_i[PAGE_W-1 -: JHI_W], lit_i};
      SRC_RET:  next_o = pop_addr_i;
      default:  next_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int unsigned PC_W   = pc_pkg::PC_W,
  parameter int unsigned BYTE_W = pc_pkg::BYTE_W,
  parameter int unsigned LIT_W  = pc_pkg::LIT_W,
  localparam int unsigned PAGE_W = PC_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              lo_wr_i,
  input  logic [BYTE_W-1:0] lo_data_i,
  input  logic              page_wr_i,
  input  logic [PAGE_W-1:0] page_data_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic [LIT_W-1:0]  lit_i,
  input  logic              ret_i,
  input  logic [PC_W-1:0]   pop_addr_i,
  output logic              push_o,
  output logic [PC_W-1:0]   push_addr_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [BYTE_W-1:0] lo_o
);
  import pc_pkg::*;

  logic [PAGE_W-1:0] page;
  logic [PC_W-1:0]   pc_q, pc_d, pc_seq;
  pc_src_e           src;

  pc_page_latch #(.PAGE_W(PAGE_W)) i_page (
    .clk_i, .rst_ni, .wr_i(page_wr_i), .data_i(page_data_i), .page_o(page)
  );

  pc_src_sel i_sel (
    .inc_i, .lo_wr_i, .jump_i, .ret_i, .src_o(src)
  );

  pc_next_addr #(.PC_W(PC_W), .BYTE_W(BYTE_W), .LIT_W(LIT_W)) i_next (
    .src_i(src), .pc_i(pc_q), .page_i(page), .lo_data_i, .lit_i,
    .pop_addr_i, .seq_o(pc_seq), .next_o(pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o        = pc_q;
  assign lo_o        = pc_q[BYTE_W-1:0];
  assign push_o      = jump_i & call_i & ~ret_i;
  assign push_addr_o = pc_seq;

  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !lo_wr_i && !jump_i && !ret_i |=> pc_o == $past(pc_o) + PC_W'(1)); // R2
  AST_LOW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i && !jump_i && !ret_i |=> lo_o == $past(lo_data_i)); // R4
  AST_JUMP_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i && !ret_i |=> pc_o[LIT_W-1:0] == $past(lit_i)); // R5
  AST_RET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |=> pc_o == $past(pop_addr_i)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !lo_wr_i && !jump_i && !ret_i |=> $stable(pc_o)); // R9
  AST_PUSH_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> $past(push_addr_o) == $past(pc_o) + PC_W'(1)); // R6
endmodule

// File: tb/test_pc_unit.sv
module test_pc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc = 0, lo_wr = 0, page_wr = 0, jump = 0, call = 0, ret = 0;
  logic [7:0]  lo_data = '0;
  logic [4:0]  page_data = '0;
  logic [10:0] lit = '0;
  logic [12:0] pop_addr = '0;
  logic        push;
  logic [12:0] push_addr, pc;
  logic [7:0]  lo;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  pc_unit i_pc_unit (
    .clk_i(clk), .rst_ni(rst_n), .inc_i(inc), .lo_wr_i(lo_wr), .lo_data_i(lo_data),
    .page_wr_i(page_wr), .page_data_i(page_data), .jump_i(jump), .call_i(call),
    .lit_i(lit), .ret_i(ret), .pop_addr_i(pop_addr), .push_o(push),
    .push_addr_o(push_addr), .pc_o(pc), .lo_o(lo)
  );

  typedef struct packed {
    logic        inc, lo_wr, page_wr;
    logic [7:0]  d;
    logic [4:0]  pd;
    logic        jmp, cal;
    logic [10:0] lit;
    logic        ret;
    logic [12:0] pop;
    logic        e_push;
    logic [12:0] e_paddr;
    logic [12:0] e_pc;
  } vec_t;

  localparam int N = 16;
  localparam vec_t VEC [N] = '{
    '{1,0,0, 8'h00, 5'h00, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h0001}, // R2
    '{0,0,1, 8'h00, 5'h05, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h0001}, // R9 hold
    '{0,1,0, 8'h40, 5'h00, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h0540}, // R3
    '{1,1,0, 8'h80, 5'h00, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h0580}, // R4
    '{0,1,1, 8'h33, 5'h1A, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h0533}, // R8 old page
    '{1,0,0, 8'h00, 5'h00, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h0534}, // R2
    '{0,0,0, 8'h00, 5'h00, 1,0, 11'h123, 0, 13'h0000, 0, 13'h0000, 13'h1923}, // R5 R6
    '{0,0,0, 8'h00, 5'h00, 1,1, 11'h7FF, 0, 13'h0000, 1, 13'h1924, 13'h1FFF}, // R6
    '{1,0,0, 8'h00, 5'h00, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h0000}, // R2 wrap
    '{0,1,0, 8'hFF, 5'h00, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h1AFF}, // R8 kept
    '{1,0,0, 8'h00, 5'h00, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h1B00}, // R2
    '{1,1,0, 8'h11, 5'h00, 1,1, 11'h005, 1, 13'h0042, 0, 13'h0000, 13'h0042}, // R7 R9
    '{1,1,0, 8'h11, 5'h00, 1,0, 11'h005, 0, 13'h0000, 0, 13'h0000, 13'h1805}, // R9
    '{0,0,1, 8'h00, 5'h07, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h1805}, // R8
    '{0,0,0, 8'h00, 5'h00, 1,0, 11'h400, 0, 13'h0000, 0, 13'h0000, 13'h0400}, // R5 low bits
    '{0,1,0, 8'h10, 5'h00, 0,0, 11'h000, 0, 13'h0000, 0, 13'h0000, 13'h0710}  // R3
  };

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {inc, lo_wr, page_wr, jump, call, ret} = '0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset pc", pc, 13'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      inc = VEC[i].inc; lo_wr = VEC[i].lo_wr; page_wr = VEC[i].page_wr;
      lo_data = VEC[i].d; page_data = VEC[i].pd; jump = VEC[i].jmp;
      call = VEC[i].cal; lit = VEC[i].lit; ret = VEC[i].ret; pop_addr = VEC[i].pop;
      #2;
      chk("R6 push", {12'd0, push}, {12'd0, VEC[i].e_push});
      if (VEC[i].e_push) chk("R6 push addr", push_addr, VEC[i].e_paddr);
      @(negedge clk);
      chk("R9 vector pc", pc, VEC[i].e_pc);
      chk("R3 low byte", {5'd0, lo}, {5'd0, VEC[i].e_pc[7:0]});
    end
    idle();
    // R1: reset mid-run clears both address and page latch
    #3 rst_n = 1'b0;
    #2 chk("R1 async reset pc", pc, 13'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    lo_wr = 1; lo_data = 8'hAA;
    @(negedge clk);
    idle();
    chk("R1 page cleared", pc, 13'h00AA);
    // R8: page written, then a call keeps it; a return ignores it
    page_wr = 1; page_data = 5'h13;
    @(negedge clk);
    idle(); jump = 1; call = 1; lit = 11'h0F0;
    #2 chk("R6 call push addr", push_addr, 13'h00AB);
    @(negedge clk);
    idle();
    chk("R5 call target", pc, 13'h10F0);
    ret = 1; pop_addr = 13'h0ABC;
    @(negedge clk);
    idle();
    chk("R7 return", pc, 13'h0ABC);
    lo_wr = 1; lo_data = 8'h01;
    @(negedge clk);
    idle();
    chk("R8 page kept", pc, 13'h1301);
    @(negedge clk);
    chk("R9 idle hold", pc, 13'h1301);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule